// File: doc/BRIEF.md
# Audio Frame Packetizer

This block sits between an audio sampler and a radio transmit FIFO. Each assertion of a sample strobe delivers one 10-bit audio sample. The block stores samples in one of two frame buffers. When a buffer holds a complete frame, the block hands that buffer to its packing engine and goes on filling the other buffer, so no sample is dropped at a frame boundary.

The packing engine sends one status byte first. Bit 0 of that byte carries a locate request. The engine then emits the frame's samples as a continuous bit stream, most significant bit first. Each four samples form exactly five bytes. The bytes leave over a valid/ready byte port.

A mode input selects the frame length: 36 samples when low, 44 samples when high. The block samples this input only when a frame completes, and at reset.

Top module: `audio_packetizer`

## Requirements
- R1: A frame holds 36 samples when the mode input was low, and 44 samples when it was high. The mode input is read at reset and on the strobe that completes a frame. A frame therefore produces 46 or 56 output bytes.
- R2: Capture continues into the second buffer while the first is streamed out. Every strobed sample appears in the output once, in order, with none lost across frame boundaries.
- R3: Within each group of four samples s0..s3, the 40-bit word {s0,s1,s2,s3} is sent as five bytes, bits [39:32] first and bits [7:0] last.
- R4: The first byte of every frame is the status byte. Its bit 0 equals the locate input sampled on the cycle the frame is accepted for streaming. Bits [7:1] are zero.
- R5: The byte port holds out_data stable while out_valid is high and out_ready is low. A byte is consumed only on a cycle with both out_valid and out_ready high.
- R6: frame_start is a one-cycle pulse. It occurs on the cycle the status byte of a new frame is first presented, with out_valid high.
- R7: If a buffer fills while the previous frame is still streaming, overrun goes high and stays high until reset.
- R8: While reset is asserted and on the cycle after it, out_valid, frame_start and overrun are all low.
- R9: Changes on the mode input between frame boundaries have no effect on the length of the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | One-cycle strobe marking a new sample |
| smp_data | input | 10 | Audio sample, valid when smp_stb is high |
| long_mode | input | 1 | Frame length select: 0 for 36 samples, 1 for 44 samples |
| locate_req | input | 1 | Locate request copied into bit 0 of the status byte |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | out_data holds a byte |
| out_ready | input | 1 | Downstream accepts the byte |
| frame_start | output | 1 | Pulse when a frame begins streaming |
| overrun | output | 1 | Sticky: a frame completed while the previous one was still streaming |

## Verification
A buffer select that flips at the wrong point, or a write pointer that is off by one, shows up as wrong payload bytes. The first wrong byte appears in the next frame, at most one frame period after the fault. A mis-latched frame length changes the byte count between two frame_start pulses. That error is visible at the second pulse. A packer counter that skips or repeats a byte position breaks the 40-bit group pattern inside the first group it touches. The bench checks every byte against a bit-packing model. It uses all-ones, all-zeros and alternating patterns as well as random samples, so a bit slip cannot hide behind symmetric data.

// File: rtl/apk_pkg.sv
// Package: shared sizing for the audio frame packetizer.
// Assumes samples per group times sample width is a multiple of eight.
package apk_pkg;
    localparam int SMP_W     = 10;
    localparam int SHORT_LEN = 36;
    localparam int LONG_LEN  = 44;
    localparam int GRP       = 4;
endpackage

// File: rtl/apk_capture.sv
// apk_capture: writes strobed samples into one of two frame buffers and
// swaps buffers when the current frame length is reached. It reports the
// full buffer with a one-cycle pulse. A group read port returns GRP samples
// packed first-sample-highest.
// Assumes: the frame lengths are multiples of GRP, and LONG_LEN >= SHORT_LEN.
module apk_capture #(
    parameter int SMP_W     = apk_pkg::SMP_W,
    parameter int SHORT_LEN = apk_pkg::SHORT_LEN,
    parameter int LONG_LEN  = apk_pkg::LONG_LEN,
    parameter int GRP       = apk_pkg::GRP,
    localparam int IDX_W    = $clog2(LONG_LEN),
    localparam int GIDX_W   = $clog2(LONG_LEN / GRP),
    localparam int WORD_W   = GRP * SMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic [SMP_W-1:0]  din,
    input  logic              long_mode,
    input  logic              rd_sel,
    input  logic [GIDX_W-1:0] rd_grp,
    output logic [WORD_W-1:0] rd_word,
    output logic              full_pulse,
    output logic              full_sel,
    output logic              full_long
);
    logic [SMP_W-1:0] mem [2][LONG_LEN];
    logic             wr_sel;
    logic [IDX_W-1:0] wr_idx;
    logic             cur_long;
    logic [IDX_W-1:0] last_idx;

    assign last_idx = cur_long ? IDX_W'(LONG_LEN - 1) : IDX_W'(SHORT_LEN - 1);

    // Sample storage: write the strobed sample into the active buffer.
    always_ff @(posedge clk) begin
        if (stb) mem[wr_sel][wr_idx] <= din;
    end

    // Frame counter and buffer swap; the mode is latched at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_sel     <= 1'b0;
            wr_idx     <= '0;
            cur_long   <= long_mode;
            full_pulse <= 1'b0;
            full_sel   <= 1'b0;
            full_long  <= 1'b0;
        end else begin
            full_pulse <= 1'b0;
            if (stb) begin
                if (wr_idx == last_idx) begin
                    wr_idx     <= '0;
                    wr_sel     <= ~wr_sel;
                    full_pulse <= 1'b1;
                    full_sel   <= wr_sel;
                    full_long  <= cur_long;
                    cur_long   <= long_mode;
                end else begin
                    wr_idx <= wr_idx + 1'b1;
                end
            end
        end
    end

    // Group read port: one sample per slot, first sample in the top bits.
    for (genvar k = 0; k < GRP; k++) begin : g_rd
        logic [IDX_W-1:0] addr;
        assign addr = IDX_W'(IDX_W'(rd_grp) * IDX_W'(GRP)) + IDX_W'(k);
        assign rd_word[(GRP-1-k)*SMP_W +: SMP_W] = mem[rd_sel][addr];
    end
endmodule

// File: rtl/apk_packer.sv
// apk_packer: streams a full buffer as a status byte followed by the
// payload. Each group word is cut into bytes, most significant byte first.
// A new frame that arrives while the engine is busy is dropped, and the
// sticky overrun flag is set.
// Assumes: WORD_W is a multiple of 8.
module apk_packer #(
    parameter int SMP_W     = apk_pkg::SMP_W,
    parameter int SHORT_LEN = apk_pkg::SHORT_LEN,
    parameter int LONG_LEN  = apk_pkg::LONG_LEN,
    parameter int GRP       = apk_pkg::GRP,
    localparam int GIDX_W   = $clog2(LONG_LEN / GRP),
    localparam int WORD_W   = GRP * SMP_W,
    localparam int BPG      = WORD_W / 8,
    localparam int BS_W     = $clog2(BPG),
    localparam int SH_W     = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_sel,
    input  logic              start_long,
    input  logic              locate,
    input  logic [WORD_W-1:0] rd_word,
    input  logic              out_ready,
    output logic              rd_sel,
    output logic [GIDX_W-1:0] rd_grp,
    output logic [7:0]        out_data,
    output logic              out_valid,
    output logic              frame_start,
    output logic              overrun
);
    logic              busy;
    logic              in_status;
    logic [BS_W-1:0]   bsel;
    logic              long_q;
    logic              loc_q;
    logic [GIDX_W-1:0] last_grp;
    logic [SH_W-1:0]   shamt;
    logic [WORD_W-1:0] shifted;

    assign last_grp  = long_q ? GIDX_W'(LONG_LEN / GRP - 1) : GIDX_W'(SHORT_LEN / GRP - 1);
    assign shamt     = SH_W'((BPG - 1 - int'(bsel)) * 8);
    assign shifted   = rd_word >> shamt;
    assign out_valid = busy;

    // Output byte: the status byte first, then the selected slice of the group word.
    always_comb begin
        if (in_status) out_data = {7'b0, loc_q};
        else           out_data = shifted[7:0];
    end

    // Stream sequencer: step byte and group on each handshake, and accept new frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            in_status   <= 1'b0;
            bsel        <= '0;
            rd_grp      <= '0;
            rd_sel      <= 1'b0;
            long_q      <= 1'b0;
            loc_q       <= 1'b0;
            frame_start <= 1'b0;
            overrun     <= 1'b0;
        end else begin
            frame_start <= 1'b0;
            if (busy && out_ready) begin
                if (in_status) begin
                    in_status <= 1'b0;
                end else if (bsel == BS_W'(BPG - 1)) begin
                    bsel <= '0;
                    if (rd_grp == last_grp) busy <= 1'b0;
                    else                    rd_grp <= rd_grp + 1'b1;
                end else begin
                    bsel <= bsel + 1'b1;
                end
            end
            if (start) begin
                if (busy) begin
                    overrun <= 1'b1;
                end else begin
                    busy        <= 1'b1;
                    in_status   <= 1'b1;
                    bsel        <= '0;
                    rd_grp      <= '0;
                    rd_sel      <= start_sel;
                    long_q      <= start_long;
                    loc_q       <= locate;
                    frame_start <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/audio_packetizer.sv
// audio_packetizer: top level. It joins the two-buffer sample capture to
// the byte packing engine.
// Assumes: smp_stb is a single-cycle pulse spaced by enough cycles for a
// frame to drain between buffer fills.
module audio_packetizer #(
    parameter int SMP_W     = apk_pkg::SMP_W,
    parameter int SHORT_LEN = apk_pkg::SHORT_LEN,
    parameter int LONG_LEN  = apk_pkg::LONG_LEN,
    parameter int GRP       = apk_pkg::GRP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_stb,
    input  logic [SMP_W-1:0] smp_data,
    input  logic             long_mode,
    input  logic             locate_req,
    output logic [7:0]       out_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             frame_start,
    output logic             overrun
);
    localparam int GIDX_W = $clog2(LONG_LEN / GRP);
    localparam int WORD_W = GRP * SMP_W;

    logic              full_pulse, full_sel, full_long, rd_sel;
    logic [GIDX_W-1:0] rd_grp;
    logic [WORD_W-1:0] rd_word;

    apk_capture #(.SMP_W(SMP_W), .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN), .GRP(GRP)) u_cap (
        .clk(clk), .rst_n(rst_n), .stb(smp_stb), .din(smp_data), .long_mode(long_mode),
        .rd_sel(rd_sel), .rd_grp(rd_grp), .rd_word(rd_word),
        .full_pulse(full_pulse), .full_sel(full_sel), .full_long(full_long)
    );

    apk_packer #(.SMP_W(SMP_W), .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN), .GRP(GRP)) u_pack (
        .clk(clk), .rst_n(rst_n), .start(full_pulse), .start_sel(full_sel),
        .start_long(full_long), .locate(locate_req), .rd_word(rd_word),
        .out_ready(out_ready), .rd_sel(rd_sel), .rd_grp(rd_grp),
        .out_data(out_data), .out_valid(out_valid),
        .frame_start(frame_start), .overrun(overrun)
    );
endmodule

// File: rtl/audio_packetizer_chk.sv
// audio_packetizer_chk: port-level properties of the packetizer, bound to the top.
module audio_packetizer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] out_data,
    input logic       out_valid,
    input logic       out_ready,
    input logic       frame_start,
    input logic       overrun
);
    // R5: a stalled byte stays presented and unchanged.
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R7: overrun never clears outside reset.
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R6 and R4: a frame start presents a status byte with its upper bits clear.
    a_r6_start_status: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (out_valid && out_data[7:1] == 7'b0));

    // R6: frame_start lasts a single cycle.
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R8: the cycle after reset shows an idle port.
    a_r8_reset_idle: assert property (@(posedge clk)
        $rose(rst_n) |-> (!out_valid && !frame_start && !overrun));
endmodule

bind audio_packetizer audio_packetizer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .frame_start(frame_start), .overrun(overrun)
);

// File: tb/audio_packetizer_bench.sv
module audio_packetizer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NFRAMES    = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_stb = 1'b0;
    logic [9:0] smp_data = '0;
    logic       long_mode = 1'b0;
    logic       locate_req = 1'b0;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;
    logic       out_valid, frame_start, overrun;

    audio_packetizer u_audio_packetizer (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_data(smp_data),
        .long_mode(long_mode), .locate_req(locate_req), .out_data(out_data),
        .out_valid(out_valid), .out_ready(out_ready), .frame_start(frame_start),
        .overrun(overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int         n_chk = 0;
    int         n_bad = 0;
    logic [7:0] exp_q[$];
    int         len_q[$];
    int         frames_seen = 0;
    int         byte_cnt = 0;
    bit         hold_ready = 0;
    bit         mon_on = 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected bytes: status byte, then each 40-bit group word sent from its top byte down.
    function automatic void push_frame(input logic [9:0] s[44], input int len, input bit loc);
        exp_q.push_back({7'b0, loc});
        for (int g = 0; g < len / 4; g++) begin
            logic [39:0] w;
            w = {s[4*g], s[4*g+1], s[4*g+2], s[4*g+3]};
            for (int j = 0; j < 5; j++) exp_q.push_back(w[39-8*j -: 8]);
        end
        len_q.push_back(len / 4 * 5 + 1);
    endfunction

    // Monitor: drive ready at the falling edge, then record the handshake that the next rising edge completes.
    initial begin
        forever begin
            @(negedge clk);
            out_ready = hold_ready ? 1'b0 : (($urandom % 4) != 0);
            #1;
            if (rst_n && mon_on) begin
                if (frame_start) begin
                    if (frames_seen > 0) begin
                        int el;
                        el = len_q.pop_front();
                        check(byte_cnt == el, "R1 R9 bytes per frame", byte_cnt, el);
                    end
                    frames_seen++;
                    byte_cnt = 0;
                    check(out_valid && out_data[7:1] == 7'b0, "R6 R4 start with status", int'(out_data), 0);
                end
                if (out_valid && out_ready) begin
                    logic [7:0] e;
                    e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
                    check(out_data === e, "R2 R3 R4 byte value", int'(out_data), int'(e));
                    byte_cnt++;
                end
            end
        end
    end

    task automatic strobe(input logic [9:0] d);
        @(negedge clk);
        smp_stb  = 1'b1;
        smp_data = d;
        @(negedge clk);
        smp_stb = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        int unsigned seed_init;
        bit cur_long;
        seed_init = $urandom(32'd5150);
        long_mode = 1'b0;
        cur_long  = 1'b0;
        repeat (3) @(negedge clk);
        check(!out_valid && !frame_start && !overrun, "R8 idle in reset",
              int'({out_valid, frame_start, overrun}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !frame_start && !overrun, "R8 idle after reset",
              int'({out_valid, frame_start, overrun}), 0);

        for (int f = 0; f < NFRAMES; f++) begin
            logic [9:0] s[44];
            int  len;
            bit  loc, nxt;
            len = cur_long ? 44 : 36;
            loc = (f % 3 == 1);
            nxt = (f < 2) ? 1'b0 : (f < 4 ? 1'b1 : 1'($urandom));
            for (int i = 0; i < 44; i++) begin
                case (f)
                    0:       s[i] = 10'h3FF;
                    1:       s[i] = 10'h000;
                    2:       s[i] = (i % 2 == 0) ? 10'h2AA : 10'h155;
                    default: s[i] = 10'($urandom);
                endcase
            end
            for (int i = 0; i < len; i++) begin
                if (i == 5) long_mode = 1'($urandom);
                if (i == len / 2) locate_req = loc;
                if (i == len - 1) begin
                    long_mode = nxt;
                    push_frame(s, len, loc);
                end
                strobe(s[i]);
            end
            cur_long = nxt;
        end

        while (exp_q.size() > 0 || out_valid) @(negedge clk);
        repeat (2) @(negedge clk);
        mon_on = 0;
        check(len_q.size() == 1 && byte_cnt == len_q[0], "R1 last frame byte count",
              byte_cnt, (len_q.size() > 0) ? len_q[0] : -1);
        check(frames_seen == NFRAMES, "R2 R6 frame count", frames_seen, NFRAMES);
        check(!overrun, "R7 no overrun when drained", int'(overrun), 0);

        // Overrun: stall the consumer so that a second buffer fills while the first is still streaming.
        hold_ready = 1;
        for (int f = 0; f < 2; f++)
            for (int i = 0; i < 44; i++) strobe(10'($urandom));
        check(overrun, "R7 overrun set", int'(overrun), 1);
        check(out_valid, "R5 stalled byte still offered", int'(out_valid), 1);
        hold_ready = 0;
        repeat (300) @(negedge clk);
        check(overrun, "R7 overrun sticky", int'(overrun), 1);

        summary();
        $finish;
    end
endmodule